// File: doc/BRIEF.md
# Address-Sequence Command Detector

This block watches a stream of completed memory access cycles, each presented as a 17-bit address and a write qualifier. It looks for a fixed six-step chain of read addresses hidden inside ordinary traffic. The first five reads form an unlock prefix. The sixth read selects one of four commands: nonvolatile store, nonvolatile recall, automatic-store disable or automatic-store enable. The reads themselves are still served by the memory as normal. This block only observes them. It does not hold the array and does not execute the commands.

Only the low 16 address bits take part in the match. Any write, or any read off the expected chain, cancels the partial match without issuing a command. An offending read is re-examined as a possible first step. A store or recall raises an IO lockout that holds until the executing logic reports completion. Accesses offered while the lockout is high are ignored.

The access input is a valid/ready stream. `acc_ready_o` is always high, so the block never applies back-pressure. A beat counts on every clock edge at which `acc_valid_i` is high. Cycles with `acc_valid_i` low carry no access and leave the match state unchanged.

Top module: `seqcmd_detect`

## Requirements
- R1: After reset the match state is idle and every command pulse and `io_lock_o` are low. A reset in the middle of a chain discards the partial match.
- R2: The prefix reads 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F, in that order, followed by a read of 0x8FC0 raise `cmd_store_o` for exactly one clock, starting at the edge that accepts the sixth read.
- R3: The same prefix followed by a read of 0x4C63 raises `cmd_recall_o` for exactly one clock.
- R4: The same prefix followed by a read of 0x8B45 pulses `cmd_as_dis_o`, and followed by 0x4B46 it pulses `cmd_as_en_o`. Neither of these raises `io_lock_o`.
- R5: Only address bits [15:0] are compared. Bit 16 has no effect on any step.
- R6: A write beat (`acc_write_i`=1) at any point in the chain cancels it. A chain resumed after the write issues no command.
- R7: A read whose low 16 bits differ from the next expected address cancels the chain. A sixth read at a non-command address issues nothing.
- R8: A read that cancels a chain but equals 0x4E38 in its low 16 bits counts as the first prefix step.
- R9: A store or recall sets `io_lock_o` at the same edge as its pulse. `io_lock_o` stays high until the edge at which `op_done_i` is sampled high, and it is low from that edge on.
- R10: Beats offered while `io_lock_o` is high are ignored. They neither advance the chain nor issue any command.
- R11: `acc_ready_o` is always high. Idle cycles with `acc_valid_i` low between steps do not cancel the chain.
- R12: At most one command pulse is high in any cycle, and no pulse lasts two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | A completed access is offered this cycle |
| acc_ready_o | output | 1 | Always high; the block never stalls the stream |
| acc_addr_i | input | 17 | Address of the offered access |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| op_done_i | input | 1 | Completion of a store or recall operation |
| cmd_store_o | output | 1 | One-clock store command pulse |
| cmd_recall_o | output | 1 | One-clock recall command pulse |
| cmd_as_dis_o | output | 1 | One-clock automatic-store disable pulse |
| cmd_as_en_o | output | 1 | One-clock automatic-store enable pulse |
| io_lock_o | output | 1 | IO lockout, high from a store or recall until completion |

## Verification
Each command pulse, and the rise of `io_lock_o`, is registered at the rising edge that accepts the sixth read. Each is therefore due one edge after that read is driven, and the pulse is gone again one edge later. `io_lock_o` falls at the edge that samples `op_done_i`. The bench drives every beat on a falling edge and compares all five outputs at the next falling edge, so each result is checked in the cycle it is due and again in the cycle it must have cleared.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

  localparam int PREFIX_LEN = 5;

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_STORE  = 3'd1,
    CMD_RECALL = 3'd2,
    CMD_AS_DIS = 3'd3,
    CMD_AS_EN  = 3'd4
  } cmd_e;

  // Unlock chain, index = step number; the order is behaviour.
  function automatic logic [15:0] prefix_key(input int idx);
    case (idx)
      0:       prefix_key = 16'h4E38;
      1:       prefix_key = 16'hB1C7;
      2:       prefix_key = 16'h83E0;
      3:       prefix_key = 16'h7C1F;
      default: prefix_key = 16'h703F;
    endcase
  endfunction

  localparam logic [15:0] KEY_STORE  = 16'h8FC0;
  localparam logic [15:0] KEY_RECALL = 16'h4C63;
  localparam logic [15:0] KEY_AS_DIS = 16'h8B45;
  localparam logic [15:0] KEY_AS_EN  = 16'h4B46;

endpackage

// File: rtl/seqcmd_match.sv
module seqcmd_match
  import seqcmd_pkg::*;
#(
  parameter int KEY_W  = 16,
  parameter int STEP_W = 3
) (
  input  logic [KEY_W-1:0]  key_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              hit_next_o,
  output logic              hit_first_o,
  output cmd_e              cmd_hit_o
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(PREFIX_LEN);

  logic [PREFIX_LEN-1:0] eq;

  for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_cmp
    assign eq[g] = (key_i == KEY_W'(prefix_key(g)));
  end

  assign hit_first_o = eq[0];

  always_comb begin
    hit_next_o = 1'b0;
    if (step_i < LAST_STEP) hit_next_o = eq[step_i];
  end

  always_comb begin
    cmd_hit_o = CMD_NONE;
    if (step_i == LAST_STEP) begin
      if      (key_i == KEY_W'(KEY_STORE))  cmd_hit_o = CMD_STORE;
      else if (key_i == KEY_W'(KEY_RECALL)) cmd_hit_o = CMD_RECALL;
      else if (key_i == KEY_W'(KEY_AS_DIS)) cmd_hit_o = CMD_AS_DIS;
      else if (key_i == KEY_W'(KEY_AS_EN))  cmd_hit_o = CMD_AS_EN;
    end
  end

endmodule

// File: rtl/seqcmd_seq.sv
module seqcmd_seq
  import seqcmd_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              write_i,
  input  logic              hit_next_i,
  input  logic              hit_first_i,
  input  cmd_e              cmd_hit_i,
  output logic [STEP_W-1:0] step_o,
  output cmd_e              fire_o,
  output cmd_e              cmd_q_o
);

  logic [STEP_W-1:0] step_q, step_n;
  cmd_e              fire;

  always_comb begin
    step_n = step_q;
    fire   = CMD_NONE;
    if (take_i) begin
      if (write_i) begin
        step_n = '0;
      end else if (cmd_hit_i != CMD_NONE) begin
        fire   = cmd_hit_i;
        step_n = '0;
      end else if (hit_next_i) begin
        step_n = step_q + STEP_W'(1);
      end else if (hit_first_i) begin
        step_n = STEP_W'(1);
      end else begin
        step_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= '0;
      cmd_q_o <= CMD_NONE;
    end else begin
      step_q  <= step_n;
      cmd_q_o <= fire;
    end
  end

  assign step_o = step_q;
  assign fire_o = fire;

endmodule

// File: rtl/seqcmd_lock.sv
module seqcmd_lock
  import seqcmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_e fire_i,
  input  logic done_i,
  output logic lock_o
);

  logic set_lock;
  assign set_lock = (fire_i == CMD_STORE) || (fire_i == CMD_RECALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_o <= 1'b0;
    else if (set_lock) lock_o <= 1'b1;
    else if (done_i)   lock_o <= 1'b0;
  end

endmodule

// File: rtl/seqcmd_detect.sv
module seqcmd_detect
  import seqcmd_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int KEY_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid_i,
  output logic              acc_ready_o,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_write_i,
  input  logic              op_done_i,
  output logic              cmd_store_o,
  output logic              cmd_recall_o,
  output logic              cmd_as_dis_o,
  output logic              cmd_as_en_o,
  output logic              io_lock_o
);

  localparam int STEP_W = $clog2(PREFIX_LEN + 1);

  logic [KEY_W-1:0]  key;
  logic [STEP_W-1:0] step;
  logic              hit_next, hit_first, take;
  cmd_e              cmd_hit, fire, cmd_q;
  logic [ADDR_W-KEY_W-1:0] unused_addr_hi;

  assign key            = acc_addr_i[KEY_W-1:0];
  assign unused_addr_hi = acc_addr_i[ADDR_W-1:KEY_W];
  assign take           = acc_valid_i && !io_lock_o;
  assign acc_ready_o    = 1'b1;

  seqcmd_match #(.KEY_W(KEY_W), .STEP_W(STEP_W)) u_match (
    .key_i       (key),
    .step_i      (step),
    .hit_next_o  (hit_next),
    .hit_first_o (hit_first),
    .cmd_hit_o   (cmd_hit)
  );

  seqcmd_seq #(.STEP_W(STEP_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take),
    .write_i     (acc_write_i),
    .hit_next_i  (hit_next),
    .hit_first_i (hit_first),
    .cmd_hit_i   (cmd_hit),
    .step_o      (step),
    .fire_o      (fire),
    .cmd_q_o     (cmd_q)
  );

  seqcmd_lock u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (fire),
    .done_i (op_done_i),
    .lock_o (io_lock_o)
  );

  assign cmd_store_o  = (cmd_q == CMD_STORE);
  assign cmd_recall_o = (cmd_q == CMD_RECALL);
  assign cmd_as_dis_o = (cmd_q == CMD_AS_DIS);
  assign cmd_as_en_o  = (cmd_q == CMD_AS_EN);

endmodule

// File: rtl/seqcmd_detect_sva.sv
module seqcmd_detect_sva (
  input logic clk,
  input logic rst_n,
  input logic acc_valid_i,
  input logic acc_write_i,
  input logic op_done_i,
  input logic cmd_store_o,
  input logic cmd_recall_o,
  input logic cmd_as_dis_o,
  input logic cmd_as_en_o,
  input logic io_lock_o
);

  logic any_cmd;
  assign any_cmd = cmd_store_o | cmd_recall_o | cmd_as_dis_o | cmd_as_en_o;

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_store_o, cmd_recall_o, cmd_as_dis_o, cmd_as_en_o})); // R12
  AST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd |=> !any_cmd); // R2
  AST_LOCK_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_store_o || cmd_recall_o) |-> io_lock_o); // R9
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_lock_o && !op_done_i) |=> io_lock_o); // R9
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (io_lock_o && op_done_i) |=> !io_lock_o); // R9
  AST_LOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    io_lock_o |=> !any_cmd); // R10
  AST_WRITE_NOCMD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && acc_write_i) |=> !any_cmd); // R6
  AST_AS_NOLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_as_dis_o || cmd_as_en_o) |-> !io_lock_o); // R4

endmodule

bind seqcmd_detect seqcmd_detect_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_valid_i  (acc_valid_i),
  .acc_write_i  (acc_write_i),
  .op_done_i    (op_done_i),
  .cmd_store_o  (cmd_store_o),
  .cmd_recall_o (cmd_recall_o),
  .cmd_as_dis_o (cmd_as_dis_o),
  .cmd_as_en_o  (cmd_as_en_o),
  .io_lock_o    (io_lock_o)
);

// File: tb/seqcmd_detect_bench.sv
`timescale 1ns/100ps
module seqcmd_detect_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [16:0] acc_addr = '0;
  logic        op_done = 1'b0;
  logic        acc_ready;
  logic        c_st, c_rc, c_dis, c_en, lock;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  seqcmd_detect u_seqcmd_detect (
    .clk (clk), .rst_n (rst_n),
    .acc_valid_i (acc_valid), .acc_ready_o (acc_ready),
    .acc_addr_i (acc_addr), .acc_write_i (acc_write),
    .op_done_i (op_done),
    .cmd_store_o (c_st), .cmd_recall_o (c_rc),
    .cmd_as_dis_o (c_dis), .cmd_as_en_o (c_en),
    .io_lock_o (lock)
  );

  // Expected output bits: {store, recall, as_dis, as_en, lock}
  typedef struct packed {
    logic        v;
    logic        w;
    logic [16:0] a;
    logic        d;
    logic [4:0]  e;
    logic [3:0]  req;
  } tv_t;

  function automatic tv_t mk(input logic v, input logic w, input logic [16:0] a,
                             input logic d, input logic [4:0] e, input logic [3:0] req);
    mk = '{v: v, w: w, a: a, d: d, e: e, req: req};
  endfunction

  localparam int NV = 61;
  localparam tv_t TBL [NV] = '{
    // R2 store chain, R9 lock held then released by op_done
    mk(1,0,17'h04E38,0,5'b00000,2), mk(1,0,17'h0B1C7,0,5'b00000,2),
    mk(1,0,17'h083E0,0,5'b00000,2), mk(1,0,17'h07C1F,0,5'b00000,2),
    mk(1,0,17'h0703F,0,5'b00000,2), mk(1,0,17'h08FC0,0,5'b10001,2),
    mk(0,0,17'h00000,0,5'b00001,9), mk(0,0,17'h00000,0,5'b00001,9),
    mk(0,0,17'h00000,1,5'b00000,9),
    // R3 recall with R5 address bit 16 set
    mk(1,0,17'h14E38,0,5'b00000,5), mk(1,0,17'h0B1C7,0,5'b00000,5),
    mk(1,0,17'h183E0,0,5'b00000,5), mk(1,0,17'h07C1F,0,5'b00000,5),
    mk(1,0,17'h1703F,0,5'b00000,5), mk(1,0,17'h14C63,0,5'b01001,3),
    mk(0,0,17'h00000,1,5'b00000,9),
    // R4 disable, R11 idle gaps inside the chain
    mk(1,0,17'h04E38,0,5'b00000,11), mk(0,0,17'h00000,0,5'b00000,11),
    mk(1,0,17'h0B1C7,0,5'b00000,11), mk(1,0,17'h083E0,0,5'b00000,11),
    mk(1,0,17'h07C1F,0,5'b00000,11), mk(0,0,17'h00000,0,5'b00000,11),
    mk(1,0,17'h0703F,0,5'b00000,11), mk(1,0,17'h08B45,0,5'b00100,4),
    mk(0,0,17'h00000,0,5'b00000,12),
    // R4 enable
    mk(1,0,17'h04E38,0,5'b00000,4), mk(1,0,17'h0B1C7,0,5'b00000,4),
    mk(1,0,17'h083E0,0,5'b00000,4), mk(1,0,17'h07C1F,0,5'b00000,4),
    mk(1,0,17'h0703F,0,5'b00000,4), mk(1,0,17'h04B46,0,5'b00010,4),
    mk(0,0,17'h00000,0,5'b00000,12),
    // R6 write aborts the chain
    mk(1,0,17'h04E38,0,5'b00000,6), mk(1,0,17'h0B1C7,0,5'b00000,6),
    mk(1,1,17'h083E0,0,5'b00000,6), mk(1,0,17'h083E0,0,5'b00000,6),
    mk(1,0,17'h07C1F,0,5'b00000,6), mk(1,0,17'h0703F,0,5'b00000,6),
    mk(1,0,17'h08FC0,0,5'b00000,6),
    // R7 mismatching read aborts
    mk(1,0,17'h04E38,0,5'b00000,7), mk(1,0,17'h0B1C7,0,5'b00000,7),
    mk(1,0,17'h01234,0,5'b00000,7), mk(1,0,17'h083E0,0,5'b00000,7),
    mk(1,0,17'h07C1F,0,5'b00000,7), mk(1,0,17'h0703F,0,5'b00000,7),
    mk(1,0,17'h04C63,0,5'b00000,7),
    // R7 sixth read at a non-command address
    mk(1,0,17'h04E38,0,5'b00000,7), mk(1,0,17'h0B1C7,0,5'b00000,7),
    mk(1,0,17'h083E0,0,5'b00000,7), mk(1,0,17'h07C1F,0,5'b00000,7),
    mk(1,0,17'h0703F,0,5'b00000,7), mk(1,0,17'h00000,0,5'b00000,7),
    mk(1,0,17'h08FC0,0,5'b00000,7),
    // R8 aborting read of the first key restarts the chain
    mk(1,0,17'h04E38,0,5'b00000,8), mk(1,0,17'h0B1C7,0,5'b00000,8),
    mk(1,0,17'h04E38,0,5'b00000,8), mk(1,0,17'h0B1C7,0,5'b00000,8),
    mk(1,0,17'h083E0,0,5'b00000,8), mk(1,0,17'h07C1F,0,5'b00000,8),
    mk(1,0,17'h0703F,0,5'b00000,8), mk(1,0,17'h08B45,0,5'b00100,8)
  };

  function automatic logic [4:0] outs();
    outs = {c_st, c_rc, c_dis, c_en, lock};
  endfunction

  task automatic chk(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b expected=%b (store,recall,dis,en,lock)", req, got, exp);
    end
  endtask

  // Drive one cycle at the current falling edge, return at the next one.
  task automatic beat(input logic v, input logic w, input logic [16:0] a, input logic d);
    acc_valid = v; acc_write = w; acc_addr = a; op_done = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; op_done = 1'b0;
  endtask

  task automatic prefix();
    beat(1,0,17'h04E38,0); beat(1,0,17'h0B1C7,0); beat(1,0,17'h083E0,0);
    beat(1,0,17'h07C1F,0); beat(1,0,17'h0703F,0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", outs(), 5'b00000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset release", outs(), 5'b00000);
    checks++;
    if (acc_ready !== 1'b1) begin
      failures++;
      $display("FAIL R11 acc_ready got=%b expected=1", acc_ready);
    end

    for (int i = 0; i < NV; i++) begin
      acc_valid = TBL[i].v; acc_write = TBL[i].w; acc_addr = TBL[i].a; op_done = TBL[i].d;
      @(negedge clk);
      checks++;
      if (outs() !== TBL[i].e) begin
        failures++;
        $display("FAIL R%0d row=%0d got=%b expected=%b", TBL[i].req, i, outs(), TBL[i].e);
      end
    end
    acc_valid = 1'b0; op_done = 1'b0;
    @(negedge clk);

    // R10: full recall chain while locked is ignored
    prefix(); beat(1,0,17'h08FC0,0);
    chk("R10 store sets lock", outs(), 5'b10001);
    prefix();
    chk("R10 prefix while locked", outs(), 5'b00001);
    beat(1,0,17'h04C63,0);
    chk("R10 recall ignored while locked", outs(), 5'b00001);
    // R10: prefix read while locked did not count after release
    beat(0,0,17'h0,1);
    chk("R9 lock released", outs(), 5'b00000);
    beat(1,0,17'h08FC0,0);
    chk("R10 no carry-over of locked reads", outs(), 5'b00000);
    beat(1,0,17'h04C63,0);
    chk("R10 no carry-over recall", outs(), 5'b00000);

    // R1: reset mid-chain discards progress
    prefix();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-chain", outs(), 5'b00000);
    rst_n = 1'b1;
    @(negedge clk);
    beat(1,0,17'h08FC0,0);
    chk("R1 chain lost after reset", outs(), 5'b00000);

    // R8: cancel at step 6 by first key restarts
    prefix(); beat(1,0,17'h04E38,0);
    chk("R8 restart from final step", outs(), 5'b00000);
    beat(1,0,17'h0B1C7,0); beat(1,0,17'h083E0,0); beat(1,0,17'h07C1F,0);
    beat(1,0,17'h0703F,0); beat(1,0,17'h04B46,0);
    chk("R8 enable after restart", outs(), 5'b00010);
    @(negedge clk);
    chk("R12 pulse lasts one clock", outs(), 5'b00000);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule